// File: doc/BRIEF.md
# Non-multiplexed 16-bit host bus master

This block runs single read and write cycles to external 16-bit peripherals over separate address and data pins. An internal requester presents a word address, a direction, two byte enables and write data. The block turns that request into a pin-level cycle and returns read data together with a one-cycle response pulse.

A three-bit arrangement code chooses how the upper address outputs are used. They can carry an address-latch strobe, one to four active-low chip selects, or both. A separate flag turns the top two address outputs into active-low byte-lane selects. The code therefore sets how many address bits reach the pins and whether the cycle opens with a latch pulse. A ready input from the peripheral can stretch the strobe phase. The data bus is presented as a pad-ready triple: a drive value, an output enable and a sampled input.

Top module: `hb16_nmux_master`

## Requirements
- R1: After reset and whenever idle: `req_ready_o`=1, `rd_n_o`=`wr_n_o`=1, `cs_n_o`=4'hF, `bsel_n_o`=2'b11, `ale_o`=0, `hd_oe_o`=0, `addr_o`=0.
- R2: An accepted request (`req_valid_i` and `req_ready_o` at a rising edge) is followed by exactly one address cycle with both strobes high. Then comes a strobe phase of at least `STRB_MIN` cycles with `rd_n_o` (read) or `wr_n_o` (write) low. Then comes one hold cycle with both strobes high and `rsp_valid_o`=1. Then the block is idle. Address, chip selects and byte selects stay constant from the address cycle through the hold cycle.
- R3: Address reach per code, without byte selects: 0→12, 1→12, 2→11, 3→10, 7→21, 5→19 bits. `addr_o` carries the low reach bits of `req_addr_i`, and higher `addr_o` bits are 0.
- R4: Chip-select index = the `req_addr_i` bits just above the reach (1 bit for two selects, 2 bits for three or four selects). Code 0 drives no select. Code 1 always drives `cs_n_o[0]`. Codes 2 and 3 drive `cs_n_o[index]`. Code 5 drives `cs_n_o[index]`. Code 7 maps index 0,1,2 to `cs_n_o[0]`,`[2]`,`[3]`, and index 3 drives none. `cs_n_o[1]` is never used by code 7.
- R5: `ale_o` is high during the address cycle only, and only for codes 0 and 3.
- R6: For every code except 0, the strobe phase lasts until `rdy_i` is high at a rising edge after at least `STRB_MIN` strobe cycles. Code 0 ignores `rdy_i`, so its strobe phase is exactly `STRB_MIN` cycles.
- R7: With `cfg_bsel_i`=1 the reach drops by 2 bits, and during the cycle `bsel_n_o[k]` = NOT `req_be_i[k]` (bit 0 is the low byte lane, bit 1 the high lane). With `cfg_bsel_i`=0 both byte selects stay high.
- R8: On a write, `hd_oe_o`=1 and `hd_o`=write data from the address cycle through the hold cycle. On a read, `hd_oe_o` stays 0.
- R9: On a read, `hd_i` is sampled at the edge that ends the strobe phase and shown on `rsp_rdata_o` during the hold cycle.
- R10: Arrangement inputs are sampled only at acceptance. Changes during a cycle have no effect on that cycle.
- R11: At most one chip select is low, and the two strobes are never low together.
- R12: Unlisted codes 4 and 6 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cs_i | input | 3 | Select/latch arrangement code |
| cfg_bsel_i | input | 1 | Enable byte-lane selects |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | 23 | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 2 | Byte enables, bit 0 low lane |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Cycle complete (hold cycle) |
| rsp_rdata_o | output | 16 | Read data |
| addr_o | output | 21 | Address pins |
| hd_o | output | 16 | Data bus drive value |
| hd_oe_o | output | 1 | Data bus output enable |
| hd_i | input | 16 | Data bus sampled value |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ale_o | output | 1 | Address latch pulse |
| cs_n_o | output | 4 | Chip selects, active low |
| bsel_n_o | output | 2 | Byte-lane selects, active low |
| rdy_i | input | 1 | Peripheral ready, stretches strobe |

## Verification
The hardest situation to reach is a ready-stretched strobe phase whose outputs must stay tied to the arrangement sampled at acceptance. The arrangement inputs change in the very next cycle, and the read data only becomes valid at the final strobe edge. The stimulus holds `rdy_i` low for a counted number of strobe cycles beyond the minimum and scrambles the arrangement code right after acceptance. It changes `hd_i` in the hold cycle, so that a sample taken too late or too early shows up as wrong data. The same pattern runs with code 0, where the held-low ready must have no effect on the strobe length.

// File: rtl/hb16_pkg.sv
package hb16_pkg;
  localparam int PIN_AW = 21;
  localparam int REQ_AW = PIN_AW + 2;
  localparam int DATA_W = 16;
  localparam int CS_N   = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_STRB, ST_HOLD} hb_state_e;

  // unlisted codes fall back to latch-only
  function automatic logic [2:0] norm_code(logic [2:0] c);
    return (c == 3'd4 || c == 3'd6) ? 3'd0 : c;
  endfunction

  function automatic logic [4:0] reach(logic [2:0] c, logic bsel);
    logic [4:0] w;
    case (c)
      3'd2:    w = 5'd11;
      3'd3:    w = 5'd10;
      3'd7:    w = 5'd21;
      3'd5:    w = 5'd19;
      default: w = 5'd12;
    endcase
    return bsel ? w - 5'd2 : w;
  endfunction

  function automatic logic [2:0] cs_count(logic [2:0] c);
    case (c)
      3'd1:        return 3'd1;
      3'd2, 3'd3:  return 3'd2;
      3'd7:        return 3'd3;
      3'd5:        return 3'd4;
      default:     return 3'd0;
    endcase
  endfunction

  function automatic logic has_ale(logic [2:0] c);
    return c == 3'd0 || c == 3'd3;
  endfunction
endpackage

// File: rtl/hb16_cycle_fsm.sv
module hb16_cycle_fsm
  import hb16_pkg::*;
#(
  parameter int STRB_MIN = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      rdy_ok_i,
  output hb_state_e state_o,
  output logic      capture_o
);
  localparam int CNT_W = $clog2(STRB_MIN) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRB_MIN - 1);

  hb_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             min_done;

  assign min_done  = cnt_q >= CNT_LAST;
  assign capture_o = (state_q == ST_STRB) && min_done && rdy_ok_i;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_ADDR;
        ST_ADDR: begin
          state_q <= ST_STRB;
          cnt_q   <= '0;
        end
        ST_STRB: begin
          if (!min_done) cnt_q <= cnt_q + 1'b1;
          if (capture_o) state_q <= ST_HOLD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hb16_pin_map.sv
module hb16_pin_map
  import hb16_pkg::*;
(
  input  logic [2:0]        code_i,
  input  logic              bsel_i,
  input  logic [REQ_AW-1:0] addr_i,
  input  logic              active_i,
  output logic [PIN_AW-1:0] addr_o,
  output logic [CS_N-1:0]   cs_n_o,
  output logic              ale_en_o,
  output logic              rdy_en_o
);
  logic [4:0]      aw;
  logic [2:0]      ncs;
  logic [1:0]      idx;
  logic [CS_N-1:0] sel;

  assign aw       = reach(code_i, bsel_i);
  assign ncs      = cs_count(code_i);
  assign ale_en_o = has_ale(code_i);
  assign rdy_en_o = code_i != 3'd0;

  for (genvar g = 0; g < PIN_AW; g++) begin : g_addr
    assign addr_o[g] = active_i && (aw > 5'(g)) && addr_i[g];
  end

  always_comb begin
    idx = 2'b00;
    for (int i = 0; i <= PIN_AW; i++)
      if (aw == 5'(i)) idx = addr_i[i +: 2];
  end

  always_comb begin
    sel = '0;
    case (ncs)
      3'd1: sel = 4'b0001;
      3'd2: sel = idx[0] ? 4'b0010 : 4'b0001;
      3'd3: case (idx)
              2'd0:    sel = 4'b0001;
              2'd1:    sel = 4'b0100;
              2'd2:    sel = 4'b1000;
              default: sel = 4'b0000;
            endcase
      3'd4: sel = 4'b0001 << idx;
      default: sel = '0;
    endcase
  end

  assign cs_n_o = active_i ? ~sel : '1;
endmodule

// File: rtl/hb16_nmux_master.sv
module hb16_nmux_master
  import hb16_pkg::*;
#(
  parameter int STRB_MIN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cfg_cs_i,
  input  logic              cfg_bsel_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [REQ_AW-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [PIN_AW-1:0] addr_o,
  output logic [DATA_W-1:0] hd_o,
  output logic              hd_oe_o,
  input  logic [DATA_W-1:0] hd_i,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              ale_o,
  output logic [CS_N-1:0]   cs_n_o,
  output logic [1:0]        bsel_n_o,
  input  logic              rdy_i
);
  hb_state_e         state;
  logic              accept, capture, active, ale_en, rdy_en;
  logic [2:0]        code_q;
  logic              bsel_q, we_q;
  logic [1:0]        be_q;
  logic [REQ_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign req_ready_o = state == ST_IDLE;
  assign accept      = req_valid_i && req_ready_o;
  assign active      = state != ST_IDLE;

  hb16_cycle_fsm #(.STRB_MIN(STRB_MIN)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .rdy_ok_i  (rdy_i || !rdy_en),
    .state_o   (state),
    .capture_o (capture)
  );

  hb16_pin_map i_map (
    .code_i   (code_q),
    .bsel_i   (bsel_q),
    .addr_i   (addr_q),
    .active_i (active),
    .addr_o   (addr_o),
    .cs_n_o   (cs_n_o),
    .ale_en_o (ale_en),
    .rdy_en_o (rdy_en)
  );

  // arrangement and request are frozen at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      bsel_q  <= 1'b0;
      we_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      code_q  <= norm_code(cfg_cs_i);
      bsel_q  <= cfg_bsel_i;
      we_q    <= req_we_i;
      be_q    <= req_be_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (capture && !we_q)  rdata_q <= hd_i;
  end

  assign rd_n_o      = !(state == ST_STRB && !we_q);
  assign wr_n_o      = !(state == ST_STRB && we_q);
  assign ale_o       = state == ST_ADDR && ale_en;
  assign hd_oe_o     = active && we_q;
  assign hd_o        = hd_oe_o ? wdata_q : '0;
  assign bsel_n_o    = (active && bsel_q) ? ~be_q : 2'b11;
  assign rsp_valid_o = state == ST_HOLD;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/hb16_chk.sv
module hb16_chk
  import hb16_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic              ale_o,
  input logic [CS_N-1:0]   cs_n_o,
  input logic              hd_oe_o,
  input logic [PIN_AW-1:0] addr_o,
  input logic              rsp_valid_o
);
  // R11
  one_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  // R5
  ale_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_n_o && wr_n_o));
  // R5
  ale_then_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!rd_n_o || !wr_n_o));
  // R8
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !hd_oe_o);
  // R2
  addr_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> ($stable(addr_o) && $stable(cs_n_o)));
  // R2
  hold_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rd_n_o && wr_n_o && !req_ready_o));
  // R2
  hold_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cs_n_o == '1 && !hd_oe_o && rd_n_o && wr_n_o && !ale_o));
endmodule

bind hb16_nmux_master hb16_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rd_n_o      (rd_n_o),
  .wr_n_o      (wr_n_o),
  .ale_o       (ale_o),
  .cs_n_o      (cs_n_o),
  .hd_oe_o     (hd_oe_o),
  .addr_o      (addr_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/test_hb16_nmux_master.sv
module test_hb16_nmux_master;
  import hb16_pkg::*;
  localparam int SMIN = 3;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]        cfg_cs_i = '0;
  logic              cfg_bsel_i = 1'b0, req_valid_i = 1'b0, req_we_i = 1'b0, rdy_i = 1'b1;
  logic              req_ready_o, rsp_valid_o, hd_oe_o, rd_n_o, wr_n_o, ale_o;
  logic [REQ_AW-1:0] req_addr_i = '0;
  logic [1:0]        req_be_i = '0, bsel_n_o;
  logic [DATA_W-1:0] req_wdata_i = '0, rsp_rdata_o, hd_o, hd_i = '0;
  logic [PIN_AW-1:0] addr_o;
  logic [CS_N-1:0]   cs_n_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  hb16_nmux_master #(.STRB_MIN(SMIN)) i_hb16_nmux_master (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int b_reach(input logic [2:0] c, input logic b);
    int w;
    case (c)
      3'd2: w = 11; 3'd3: w = 10; 3'd7: w = 21; 3'd5: w = 19; default: w = 12;
    endcase
    return b ? w - 2 : w;
  endfunction

  function automatic logic [3:0] b_cs_n(input logic [2:0] c, input logic b, input logic [22:0] a);
    int ix;
    ix = int'((a >> b_reach(c, b)) & 23'd3);
    case (c)
      3'd1: return 4'b1110;
      3'd2, 3'd3: return (ix % 2 == 1) ? 4'b1101 : 4'b1110;
      3'd5: return ~(4'b0001 << ix);
      3'd7: case (ix) 0: return 4'b1110; 1: return 4'b1011; 2: return 4'b0111; default: return 4'b1111; endcase
      default: return 4'b1111;
    endcase
  endfunction

  task automatic run_xfer(input logic [2:0] c, input logic b, input logic we, input logic [22:0] a,
                          input logic [1:0] be, input logic [15:0] wd, input int rdwait,
                          input logic [15:0] rd, input string tag);
    logic [20:0] ea;
    logic [3:0]  ecs;
    logic        eale, ruse, done;
    logic [2:0]  cn;
    int          n, elen;
    cn   = (c == 3'd4 || c == 3'd6) ? 3'd0 : c;
    ea   = 21'(a & ((23'd1 << b_reach(cn, b)) - 23'd1));
    ecs  = b_cs_n(cn, b, a);
    eale = (cn == 3'd0 || cn == 3'd3);
    ruse = cn != 3'd0;
    elen = ruse ? SMIN + rdwait : SMIN;
    @(negedge clk_i);
    cfg_cs_i = c; cfg_bsel_i = b; req_we_i = we; req_addr_i = a;
    req_be_i = be; req_wdata_i = wd; req_valid_i = 1'b1; rdy_i = (rdwait == 0);
    chk(req_ready_o == 1'b1, {"R2 ready ", tag}, 32'(req_ready_o), 1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    // address cycle
    chk(addr_o == ea, {"R3 addr ", tag}, 32'(addr_o), 32'(ea));
    chk(cs_n_o == ecs, {"R4 cs ", tag}, 32'(cs_n_o), 32'(ecs));
    chk(ale_o == eale, {(c != cn) ? "R12 ale " : "R5 ale ", tag}, 32'(ale_o), 32'(eale));
    chk(bsel_n_o == (b ? ~be : 2'b11), {"R7 bsel ", tag}, 32'(bsel_n_o), 32'(b ? ~be : 2'b11));
    chk(rd_n_o && wr_n_o, {"R2 addr-phase strobes ", tag}, {rd_n_o, wr_n_o}, 3);
    chk(hd_oe_o == we && (!we || hd_o == wd), {"R8 drive ", tag}, {hd_oe_o, hd_o}, {we, we ? wd : 16'h0});
    cfg_cs_i = c ^ 3'd2; cfg_bsel_i = ~b;  // R10: scramble after acceptance
    n = 0; done = 0;
    for (int k = 0; k < 64 && !done; k++) begin
      @(negedge clk_i);
      if ((we ? wr_n_o : rd_n_o) == 1'b0) begin
        n++;
        hd_i = rd;
        if (addr_o != ea || cs_n_o != ecs || ale_o)
          chk(0, {"R10 strobe-phase pins ", tag}, {addr_o, cs_n_o}, {ea, ecs});
        if (n == SMIN + rdwait) rdy_i = 1'b1;
      end else done = 1;
    end
    hd_i = ~rd;
    // hold cycle
    chk(n == elen, {ruse ? "R6 strobe length " : "R6 rdy ignored ", tag}, n, elen);
    chk(rsp_valid_o && rd_n_o && wr_n_o, {"R2 hold ", tag}, {rsp_valid_o, rd_n_o, wr_n_o}, 7);
    chk(addr_o == ea && cs_n_o == ecs, {"R10 hold pins ", tag}, {addr_o, cs_n_o}, {ea, ecs});
    if (we) chk(hd_oe_o && hd_o == wd, {"R8 hold drive ", tag}, hd_o, wd);
    else    chk(rsp_rdata_o == rd, {"R9 rdata ", tag}, rsp_rdata_o, rd);
    @(negedge clk_i);
    chk(req_ready_o && cs_n_o == 4'hF && !rsp_valid_o, {"R2 back idle ", tag},
        {req_ready_o, cs_n_o, rsp_valid_o}, 32'h1F << 1);
    rdy_i = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(req_ready_o && rd_n_o && wr_n_o && cs_n_o == 4'hF && bsel_n_o == 2'b11 &&
        !ale_o && !hd_oe_o && addr_o == '0, "R1 reset state",
        {req_ready_o, rd_n_o, wr_n_o, cs_n_o, bsel_n_o, ale_o, hd_oe_o}, 32'h1FF << 2);
  endtask

  task automatic t_latch_only;  // R5 R6 R8 R3
    run_xfer(3'd0, 1'b0, 1'b1, 23'h5A5ABC, 2'b11, 16'hBEEF, 3, 16'h0, "code0 write");
  endtask
  task automatic t_one_cs;      // R9 R6 R4
    run_xfer(3'd1, 1'b0, 1'b0, 23'h7FF123, 2'b11, 16'h0, 2, 16'hC3A5, "code1 read");
  endtask
  task automatic t_two_cs;      // R4
    run_xfer(3'd2, 1'b0, 1'b0, 23'h000923, 2'b11, 16'h0, 0, 16'h1234, "code2 idx1");
  endtask
  task automatic t_ale_two_bsel;  // R7 R5
    run_xfer(3'd3, 1'b1, 1'b1, 23'h000155, 2'b10, 16'hA55A, 1, 16'h0, "code3 bsel");
  endtask
  task automatic t_three_cs;    // R4 three-select mapping
    run_xfer(3'd7, 1'b0, 1'b1, (23'd1 << 21) | 23'h1F0F0, 2'b11, 16'h0F0F, 0, 16'h0, "code7 idx1");
    run_xfer(3'd7, 1'b0, 1'b0, (23'd3 << 21) | 23'h00042, 2'b11, 16'h0, 1, 16'h8001, "code7 idx3");
    run_xfer(3'd7, 1'b1, 1'b0, (23'd2 << 19) | 23'h7ABCD, 2'b01, 16'h0, 0, 16'h7E7E, "code7 bsel idx2");
  endtask
  task automatic t_four_cs;     // R4 R7
    run_xfer(3'd5, 1'b1, 1'b0, (23'd3 << 17) | 23'h1ABCD, 2'b01, 16'h0, 4, 16'h5AA5, "code5 bsel idx3");
  endtask
  task automatic t_unlisted;    // R12
    run_xfer(3'd6, 1'b0, 1'b0, 23'h3FFFFF, 2'b11, 16'h0, 2, 16'h0BAD, "code6");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_latch_only();
    t_one_cs();
    t_two_cs();
    t_ale_two_bsel();
    t_three_cs();
    t_four_cs();
    t_unlisted();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule